// File: doc/BRIEF.md
# Five-Level Third-Order Noise-Shaping Modulator

This block converts 18-bit two's complement audio samples, already interpolated to eight times the audio rate, into a stream of 3-bit codes that each take one of five levels, 0 to 4. A downstream five-level converter turns the codes back into an analog signal. Three cascaded delaying integrators form the loop filter. The output level is fed back into the input of every integrator, and a rounding quantizer with five levels closes the loop. The quantization error is pushed toward high frequencies, and the low-frequency average of the codes follows the input.

The modulator advances once per clock. A ratio select input sets how many modulator clocks each input sample covers: six for a 384-times system clock and eight for a 256-times system clock. The block raises a request strobe once per hold period, and the upstream interpolator answers with a valid-qualified sample. The block keeps replaying the last sample it captured until a new one arrives. Feedback levels are -2, -1, 0, +1 and +2 steps, where one step is a quarter of the input span (2^16 input LSBs). The integrators saturate at their own word width.

Top module: `dsm5_mod`

## Requirements
- R1: While reset is high and on the first cycle after a reset cycle, out_code is 2 (the mid level) and out_valid is 0. smp_req stays 0 while reset is high.
- R2: out_code never takes a value above 4.
- R3: From the second cycle after reset falls, out_valid is 1 on every clock.
- R4: smp_req pulses once every 6 clocks when ratio_sel is 0 (384-times mode) and once every 8 clocks when ratio_sel is 1 (256-times mode).
- R5: A sample presented with in_valid high is used from the next clock and is held until the next in_valid. While in_valid stays low the held sample does not change, so a single load still makes the average track that sample.
- R6: From reset with a zero input, every output code is exactly 2.
- R7: For a constant input u, the sum of (out_code - 2) * 2^16 over 4096 valid cycles stays within 2^22 of 4096 * u, in both ratio modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one code per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | 0: six clocks per sample, 1: eight clocks per sample |
| in_valid | input | 1 | Captures in_sample on this clock |
| in_sample | input | 18 | Two's complement interpolated sample |
| smp_req | output | 1 | One-clock pulse asking for the next sample |
| out_valid | output | 1 | High on every modulator cycle outside reset |
| out_code | output | 3 | Quantized level, 0 to 4 |

## Verification
The hardest condition to reach from the ports is a long window in which the modulator runs on one held sample with no reload. That is the only way to show that the hold register keeps its value instead of drifting. The bench captures one sample just after reset, keeps in_valid low for 4096 cycles while smp_req keeps pulsing, and then compares the summed codes against the held value. Other windows answer every request with the same level, so both the loaded path and the held path are compared against the same average rule in each ratio mode.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;

    typedef enum logic {
        RATIO_384 = 1'b0,
        RATIO_256 = 1'b1
    } clk_ratio_e;

    localparam int NUM_STAGES = 3;
    localparam int LVL_TOP    = 4;
    localparam int LVL_MID    = 2;

    // Clamp a signed level index to the five legal codes.
    function automatic logic [2:0] clip_level(input int lvl);
        if (lvl < 0)       return 3'd0;
        if (lvl > LVL_TOP) return 3'(LVL_TOP);
        return 3'(lvl);
    endfunction

endpackage

// File: rtl/dsm5_hold.sv
module dsm5_hold #(
    parameter int IN_W  = 18,
    parameter int LEN_A = 6,
    parameter int LEN_B = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ratio_sel,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic signed [IN_W-1:0] held,
    output logic                   req
);
    import dsm5_pkg::*;

    localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CW      = $clog2(LEN_MAX);

    clk_ratio_e      ratio;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   last;

    assign ratio = clk_ratio_e'(ratio_sel);
    assign last  = (ratio == RATIO_256) ? CW'(LEN_B - 1) : CW'(LEN_A - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else begin
            cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
            if (in_valid) held <= in_sample;
        end
    end

    assign req = !rst && (cnt == last);

endmodule

// File: rtl/dsm5_integ.sv
module dsm5_integ #(
    parameter int W       = 24,
    parameter int FB_SH   = 0,
    parameter int GAIN_SH = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] fb,
    output logic signed [W-1:0] acc
);
    localparam int EW = W + FB_SH + 2;
    localparam logic signed [EW-1:0] HI = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = ~HI;

    logic signed [EW-1:0] diff;
    logic signed [EW-1:0] step;
    logic signed [EW-1:0] sum;
    logic signed [W-1:0]  acc_n;

    always_comb begin
        diff = EW'(x) - (EW'(fb) <<< FB_SH);
        step = diff >>> GAIN_SH;
        sum  = EW'(acc) + step;
        if (sum > HI)      acc_n = HI[W-1:0];
        else if (sum < LO) acc_n = LO[W-1:0];
        else               acc_n = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_n;
    end

endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant #(
    parameter int W       = 24,
    parameter int STEP_SH = 16
) (
    input  logic signed [W-1:0] y,
    output logic [2:0]          code
);
    import dsm5_pkg::*;

    localparam int RW = W + 1;
    localparam logic signed [RW-1:0] HALF = RW'(1) <<< (STEP_SH - 1);

    logic signed [RW-1:0] rnd;

    always_comb begin
        rnd  = (RW'(y) + HALF) >>> STEP_SH;
        code = clip_level(int'(rnd) + LVL_MID);
    end

endmodule

// File: rtl/dsm5_mod.sv
module dsm5_mod #(
    parameter int IN_W     = 18,
    parameter int ACC_W    = 24,
    parameter int HOLD_384 = 6,
    parameter int HOLD_256 = 8,
    parameter int G2_SH    = 2,
    parameter int G3_SH    = 1,
    parameter int FB2_SH   = 2,
    parameter int FB3_SH   = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ratio_sel,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                   smp_req,
    output logic                   out_valid,
    output logic [2:0]             out_code
);
    import dsm5_pkg::*;

    localparam int STEP_SH = IN_W - 2;

    logic signed [IN_W-1:0]  held_smp;
    logic [2:0]              code;
    logic signed [ACC_W-1:0] lvl_s;
    logic signed [ACC_W-1:0] fb_val;
    logic signed [ACC_W-1:0] acc    [NUM_STAGES];
    logic signed [ACC_W-1:0] stg_in [NUM_STAGES];
    logic                    vld_q;

    dsm5_hold #(
        .IN_W (IN_W),
        .LEN_A(HOLD_384),
        .LEN_B(HOLD_256)
    ) i_hold (
        .clk      (clk),
        .rst      (rst),
        .ratio_sel(ratio_sel),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .held     (held_smp),
        .req      (smp_req)
    );

    assign lvl_s  = $signed({{(ACC_W-3){1'b0}}, code}) - ACC_W'(LVL_MID);
    assign fb_val = lvl_s <<< STEP_SH;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        localparam int GSH = (k == 0) ? 0 : (k == 1) ? G2_SH  : G3_SH;
        localparam int FSH = (k == 0) ? 0 : (k == 1) ? FB2_SH : FB3_SH;

        if (k == 0) begin : g_head
            assign stg_in[k] = {{(ACC_W-IN_W){held_smp[IN_W-1]}}, held_smp};
        end else begin : g_chain
            assign stg_in[k] = acc[k-1];
        end

        dsm5_integ #(
            .W      (ACC_W),
            .FB_SH  (FSH),
            .GAIN_SH(GSH)
        ) i_integ (
            .clk(clk),
            .rst(rst),
            .x  (stg_in[k]),
            .fb (fb_val),
            .acc(acc[k])
        );
    end

    dsm5_quant #(
        .W      (ACC_W),
        .STEP_SH(STEP_SH)
    ) i_quant (
        .y   (acc[NUM_STAGES-1]),
        .code(code)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= 1'b1;
    end

    assign out_valid = vld_q;
    assign out_code  = code;

endmodule

// File: rtl/dsm5_chk.sv
module dsm5_chk #(
    parameter int IN_W  = 18,
    parameter int ACC_W = 24,
    parameter int LEN_A = 6,
    parameter int LEN_B = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ratio_sel,
    input logic                    in_valid,
    input logic                    smp_req,
    input logic                    out_valid,
    input logic [2:0]              out_code,
    input logic signed [IN_W-1:0]  held,
    input logic signed [ACC_W-1:0] a0,
    input logic signed [ACC_W-1:0] a1,
    input logic signed [ACC_W-1:0] a2
);
    localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int GW      = $clog2(LEN_MAX + 2) + 1;
    localparam logic [GW-1:0] GAP_TOP = '1;

    logic [GW-1:0] gap;
    logic          seen;
    logic [GW-1:0] gap_exp;

    assign gap_exp = ratio_sel ? GW'(LEN_B) : GW'(LEN_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (smp_req) begin
            gap  <= GW'(1);
            seen <= 1'b1;
        end else if (gap != GAP_TOP) begin
            gap <= gap + 1'b1;
        end
    end

    assert_mid_on_reset_R1: assert property (@(posedge clk)
        rst |=> (out_code == 3'd2 && !out_valid));

    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
        out_code <= 3'd4);

    assert_valid_run_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_valid);

    assert_req_period_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_req && seen) |-> (gap == gap_exp));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(held));

    assert_zero_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (held == '0 && a0 == '0 && a1 == '0 && a2 == '0 && out_code == 3'd2)
        |=> (out_code == 3'd2));

endmodule

bind dsm5_mod dsm5_chk #(
    .IN_W (IN_W),
    .ACC_W(ACC_W),
    .LEN_A(HOLD_384),
    .LEN_B(HOLD_256)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .ratio_sel(ratio_sel),
    .in_valid (in_valid),
    .smp_req  (smp_req),
    .out_valid(out_valid),
    .out_code (out_code),
    .held     (held_smp),
    .a0       (acc[0]),
    .a1       (acc[1]),
    .a2       (acc[2])
);

// File: tb/test_dsm5_mod.sv
module test_dsm5_mod;

    localparam int  WIN  = 4096;
    localparam longint STEP = 65536;
    localparam longint TOL  = 64'd4194304;

    typedef struct {
        string  tag;
        longint exp_sum;
        bit     all_mid;
        int     exp_gap;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ratio_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [17:0] in_sample = '0;
    logic              smp_req;
    logic              out_valid;
    logic [2:0]        out_code;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    exp_item_t exp_q[$];
    bit        win_on = 1'b0;
    bit        answer = 1'b0;
    logic signed [17:0] level = '0;
    longint    acc_sum;
    int        mid_bad, range_bad, valid_bad, gap_bad, gap_cnt;
    bit        gap_seen;
    event      win_end;

    always #2 clk = ~clk;

    dsm5_mod i_dsm5_mod (
        .clk      (clk),
        .rst      (rst),
        .ratio_sel(ratio_sel),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .smp_req  (smp_req),
        .out_valid(out_valid),
        .out_code (out_code)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp, input bit ok);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: accumulate codes during a window
    always @(negedge clk) begin
        if (win_on) begin
            if (!out_valid) valid_bad++;
            if (out_code > 3'd4) range_bad++;
            if (out_code != 3'd2) mid_bad++;
            acc_sum += (longint'(out_code) - 2) * STEP;
            gap_cnt++;
            if (smp_req) begin
                if (gap_seen && exp_q.size() > 0 && gap_cnt != exp_q[0].exp_gap) gap_bad++;
                gap_seen = 1'b1;
                gap_cnt  = 0;
            end
        end else begin
            gap_seen = 1'b0;
            gap_cnt  = 0;
        end
    end

    // Upstream answer to sample requests
    always @(negedge clk) begin
        if (!rst && answer && smp_req) begin
            in_valid  <= 1'b1;
            in_sample <= level;
        end else if (win_on) begin
            in_valid <= 1'b0;
        end
    end

    // Scoreboard: pop and compare at window end
    initial begin
        forever begin
            @(win_end);
            if (exp_q.size() > 0) begin
                exp_item_t it;
                longint d;
                it = exp_q.pop_front();
                d  = acc_sum - it.exp_sum;
                if (d < 0) d = -d;
                chk(it.tag, "average sum", acc_sum, it.exp_sum, d <= TOL);
                if (it.all_mid) chk("R6", "codes off mid", mid_bad, 0, mid_bad == 0);
                chk("R2", "codes above 4", range_bad, 0, range_bad == 0);
                chk("R3", "cycles without valid", valid_bad, 0, valid_bad == 0);
                chk("R4", "bad request gaps", gap_bad, 0, gap_bad == 0);
            end
        end
    end

    task automatic run_case(input string tag, input logic signed [17:0] lvl,
                            input bit ratio, input bit ans, input bit rst_check);
        rst       = 1'b1;
        ratio_sel = ratio;
        answer    = 1'b0;
        in_valid  = 1'b0;
        repeat (3) @(negedge clk);
        if (rst_check) begin
            chk("R1", "code in reset", out_code, 2, out_code == 3'd2);
            chk("R1", "valid in reset", out_valid, 0, out_valid == 1'b0);
            chk("R1", "req in reset", smp_req, 0, smp_req == 1'b0);
        end
        rst = 1'b0;
        @(negedge clk);
        if (rst_check)
            chk("R1", "code after reset", out_code, 2, out_code == 3'd2);
        level     = lvl;
        in_sample = lvl;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_q.push_back('{tag: tag, exp_sum: longint'(lvl) * WIN,
                          all_mid: (lvl == 0), exp_gap: ratio ? 8 : 6});
        acc_sum   = 0;
        mid_bad   = 0;
        range_bad = 0;
        valid_bad = 0;
        gap_bad   = 0;
        answer    = ans;
        win_on    = 1'b1;
        repeat (WIN) @(negedge clk);
        win_on = 1'b0;
        answer = 1'b0;
        ->win_end;
        #1;
    endtask

    initial begin
        run_case("R6", 18'sd0, 1'b0, 1'b1, 1'b1);        // zero, six-clock hold
        run_case("R6", 18'sd0, 1'b1, 1'b1, 1'b1);        // zero, eight-clock hold
        run_case("R7", 18'sd65536, 1'b0, 1'b1, 1'b0);    // +half scale
        run_case("R7", -18'sd98304, 1'b1, 1'b1, 1'b0);   // -three quarters
        run_case("R7", 18'sd1234, 1'b1, 1'b1, 1'b0);     // small positive
        run_case("R5", 18'sd40000, 1'b0, 1'b0, 1'b0);    // single load, held
        run_case("R5", -18'sd20000, 1'b1, 1'b0, 1'b0);   // single load, held
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule